// File: doc/BRIEF.md
# Vector Element Predicate Sequencer

The sequencer turns a 4-bit predicate mode and a vector length into a stream of per-element enable decisions, one element per clock. A start pulse captures the mode and the length. The block then walks the element indices upward from zero. For each index it presents the index, an enable bit and a valid strobe. When the walk is over it pulses done.

The mode picks the source of each element's decision:
- all elements enabled;
- one bit of one of three integer predicate registers, taken as is or inverted;
- one flag of a per-element condition field, taken as is or inverted.

Condition fields are consumed starting at field 6 and wrap modulo 64. The all-zero mode is reserved. It produces no elements and raises an illegal-operation flag instead.

The predicate registers and the condition file are presented as wide inputs and read live while elements are produced. Register-file read ports, instruction decode and separate source/destination predication belong to the surrounding pipeline.

Top module: `pred_seq`

## Requirements
- R1: Reset puts the block in idle with `elem_valid`, `seq_done` and `illegal_op` low. A reset that arrives mid-sequence abandons the walk.
- R2: Mode 4'b0000 is reserved. A start with it gives `illegal_op` and `seq_done` together, for one cycle, in the cycle after the start edge, and no `elem_valid` strobes.
- R3: Mode 4'b0001 enables every element 0 to VL-1.
- R4: Modes 4'b0010 and 4'b0011 read `isrc_a`. Element i is enabled when `(isrc_a >> i) & 1` is 1 for 0010, and when it is 0 for 0011.
- R5: Modes 4'b0100/4'b0101 read `isrc_b`, and modes 4'b0110/4'b0111 read `isrc_c`. The even code enables on a set bit and the odd code on a clear bit.
- R6: Modes with bit 3 set read condition field (6 + i) mod 64 for element i. Field f occupies `cr_file[4f+3:4f]`, so element 58 reads field 0 and element 63 reads field 5.
- R7: In a condition mode, mode bits [2:1] choose the flag inside the field: 00 less-than (field bit 3), 01 greater-than (bit 2), 10 equal (bit 1), 11 summary-overflow (bit 0). Mode bit 0 = 0 enables on a set flag; mode bit 0 = 1 enables on a clear flag.
- R8: For VL > 0, element 0 is strobed in the second cycle after the start edge. Elements 1 to VL-1 follow in consecutive cycles, one per cycle, with `elem_idx` counting up by one.
- R9: `seq_done` pulses for one cycle, in the cycle after the last element strobe. For VL = 0 it pulses in the cycle after the start edge, with no strobes. A VL above 64 is treated as 64.
- R10: A start that arrives while a sequence is in progress is ignored. Mode and VL are taken only on the accepted start edge, so later changes on those inputs do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| mode | input | 4 | Predicate mode code |
| vl | input | 7 | Vector length, 0 to 64 |
| isrc_a | input | 64 | First integer predicate register |
| isrc_b | input | 64 | Second integer predicate register |
| isrc_c | input | 64 | Third integer predicate register |
| cr_file | input | 256 | 64 condition fields of 4 bits, field f at bits 4f+3..4f |
| elem_valid | output | 1 | An element decision is presented |
| elem_idx | output | 6 | Index of the presented element |
| elem_en | output | 1 | Enable decision for the presented element |
| seq_done | output | 1 | One-cycle pulse ending a sequence |
| illegal_op | output | 1 | Reserved mode seen; pulses with `seq_done` |

## Verification
Two situations are hard to reach from the ports. The first is the wrap of the condition-field index from 63 to 0. The bench reaches it with full-length runs, where VL = 64 carries the walk past element 57. One run uses a condition file in which only field 0 holds a set less-than flag, so exactly element 58 must be enabled. The second is a start that lands mid-sequence while the mode and VL inputs already hold other values. The bench changes those inputs right after every accepted start, and in one run it pulses start again partway through. The element stream must keep the mode and length of the first start.

// File: rtl/pred_seq_pkg.sv
package pred_seq_pkg;

    localparam int CR_BITS  = 4;
    localparam int CR_BASE  = 6;
    localparam int INT_SRCS = 3;

    typedef enum logic [1:0] {
        PK_RSVD,
        PK_ALL,
        PK_INT,
        PK_COND
    } pred_kind_e;

    typedef struct packed {
        pred_kind_e kind;
        logic [1:0] src;
        logic [1:0] flag;
        logic       invert;
    } pred_sel_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_FIN
    } seq_state_e;

    function automatic pred_sel_t decode_mode(input logic [3:0] m);
        pred_sel_t s;
        s.invert = m[0];
        s.flag   = m[2:1];
        s.src    = m[2:1] - 2'd1;
        if (m[3])
            s.kind = PK_COND;
        else if (m[2:1] != 2'b00)
            s.kind = PK_INT;
        else if (m[0])
            s.kind = PK_ALL;
        else
            s.kind = PK_RSVD;
        return s;
    endfunction

    function automatic logic is_reserved(input logic [3:0] m);
        return decode_mode(m).kind == PK_RSVD;
    endfunction

endpackage

// File: rtl/pred_mode_decode.sv
module pred_mode_decode
    import pred_seq_pkg::*;
(
    input  logic [3:0] mode_code,
    output pred_sel_t  sel
);
    always_comb sel = decode_mode(mode_code);
endmodule

// File: rtl/pred_elem_eval.sv
module pred_elem_eval
    import pred_seq_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int CR_FIELDS = 64,
    parameter int IDX_W     = 6,
    localparam int CR_IDX_W = $clog2(CR_FIELDS)
) (
    input  pred_sel_t                          sel,
    input  logic [IDX_W-1:0]                   idx,
    input  logic [INT_SRCS-1:0][XLEN-1:0]      isrc,
    input  logic [CR_FIELDS*CR_BITS-1:0]       cr_flat,
    output logic                               en
);
    logic [CR_BITS-1:0] fld [CR_FIELDS];

    genvar g;
    generate
        for (g = 0; g < CR_FIELDS; g++) begin : g_field
            assign fld[g] = cr_flat[g*CR_BITS +: CR_BITS];
        end
    endgenerate

    // field index wraps naturally: CR_FIELDS is a power of two, carry dropped
    logic [CR_IDX_W-1:0] fidx;
    logic [1:0]          fbit;
    logic                raw;

    assign fidx = CR_IDX_W'(CR_BASE) + CR_IDX_W'(idx);
    assign fbit = ~sel.flag;   // less-than sits in the top bit of the field

    always_comb begin
        raw = 1'b0;
        case (sel.kind)
            PK_INT: begin
                if (int'(sel.src) < INT_SRCS)
                    raw = isrc[sel.src][idx];
            end
            PK_COND: raw = fld[fidx][fbit];
            default: raw = 1'b0;
        endcase
        case (sel.kind)
            PK_ALL:  en = 1'b1;
            PK_RSVD: en = 1'b0;
            default: en = raw ^ sel.invert;
        endcase
    end
endmodule

// File: rtl/pred_seq_ctrl.sv
module pred_seq_ctrl
    import pred_seq_pkg::*;
#(
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int VL_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [3:0]       mode,
    input  logic [VL_W-1:0]  vl,
    input  logic             elem_en,
    output logic [IDX_W-1:0] cnt,
    output logic [3:0]       mode_q,
    output logic [VL_W-1:0]  vl_q,
    output logic             valid_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             en_q,
    output logic             done_q,
    output logic             illegal_q
);
    seq_state_e       state_q;
    logic [IDX_W-1:0] cnt_q;
    logic [VL_W-1:0]  vl_clamp;
    logic             last;

    assign vl_clamp = (vl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl;
    assign last     = (VL_W'(cnt_q) == vl_q - VL_W'(1));
    assign cnt      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            cnt_q     <= '0;
            mode_q    <= '0;
            vl_q      <= '0;
            valid_q   <= 1'b0;
            idx_q     <= '0;
            en_q      <= 1'b0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            valid_q   <= 1'b0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        mode_q <= mode;
                        vl_q   <= vl_clamp;
                        cnt_q  <= '0;
                        if (is_reserved(mode)) begin
                            illegal_q <= 1'b1;
                            done_q    <= 1'b1;
                        end else if (vl_clamp == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= SQ_RUN;
                        end
                    end
                end
                SQ_RUN: begin
                    valid_q <= 1'b1;
                    idx_q   <= cnt_q;
                    en_q    <= elem_en;
                    cnt_q   <= cnt_q + IDX_W'(1);
                    if (last)
                        state_q <= SQ_FIN;
                end
                SQ_FIN: begin
                    done_q  <= 1'b1;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE) |=> ($stable(mode_q) && $stable(vl_q))); // R10
    AST_RUN_LEN_OK: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_RUN) |-> (vl_q != '0 && VL_W'(cnt_q) < vl_q)); // R8
endmodule

// File: rtl/pred_seq.sv
module pred_seq
    import pred_seq_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int CR_FIELDS = 64,
    parameter int MAX_VL    = 64,
    localparam int IDX_W    = $clog2(MAX_VL),
    localparam int VL_W     = IDX_W + 1,
    localparam int CR_W     = CR_FIELDS * CR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [3:0]       mode,
    input  logic [VL_W-1:0]  vl,
    input  logic [XLEN-1:0]  isrc_a,
    input  logic [XLEN-1:0]  isrc_b,
    input  logic [XLEN-1:0]  isrc_c,
    input  logic [CR_W-1:0]  cr_file,
    output logic             elem_valid,
    output logic [IDX_W-1:0] elem_idx,
    output logic             elem_en,
    output logic             seq_done,
    output logic             illegal_op
);
    logic [INT_SRCS-1:0][XLEN-1:0] isrc;
    logic [IDX_W-1:0]              cnt;
    logic [3:0]                    mode_q;
    logic [VL_W-1:0]               vl_q;
    pred_sel_t                     sel;
    logic                          cur_en;

    assign isrc = {isrc_c, isrc_b, isrc_a};

    pred_mode_decode u_dec (
        .mode_code (mode_q),
        .sel       (sel)
    );

    pred_elem_eval #(
        .XLEN      (XLEN),
        .CR_FIELDS (CR_FIELDS),
        .IDX_W     (IDX_W)
    ) u_eval (
        .sel     (sel),
        .idx     (cnt),
        .isrc    (isrc),
        .cr_flat (cr_file),
        .en      (cur_en)
    );

    pred_seq_ctrl #(
        .MAX_VL (MAX_VL)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .vl        (vl),
        .elem_en   (cur_en),
        .cnt       (cnt),
        .mode_q    (mode_q),
        .vl_q      (vl_q),
        .valid_q   (elem_valid),
        .idx_q     (elem_idx),
        .en_q      (elem_en),
        .done_q    (seq_done),
        .illegal_q (illegal_op)
    );

    AST_ILLEGAL_ENDS: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (seq_done && !elem_valid)); // R2
    AST_ALL_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (elem_valid && sel.kind == PK_ALL) |-> elem_en); // R3
    AST_FIRST_IDX: assert property (@(posedge clk) disable iff (rst)
        (elem_valid && !$past(elem_valid)) |-> (elem_idx == '0)); // R8
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (elem_valid && $past(elem_valid)) |-> (elem_idx == $past(elem_idx) + IDX_W'(1))); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (elem_valid && VL_W'(elem_idx) == vl_q - VL_W'(1)) |=> (seq_done && !elem_valid)); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> !elem_valid); // R9
endmodule

// File: tb/tb_pred_seq.sv
module tb_pred_seq;
    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [3:0]   mode;
    logic [6:0]   vl;
    logic [63:0]  ra, rb, rc;
    logic [255:0] crf;
    logic         elem_valid, elem_en, seq_done, illegal_op;
    logic [5:0]   elem_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pred_seq dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .vl(vl),
        .isrc_a(ra), .isrc_b(rb), .isrc_c(rc), .cr_file(crf),
        .elem_valid(elem_valid), .elem_idx(elem_idx), .elem_en(elem_en),
        .seq_done(seq_done), .illegal_op(illegal_op)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic ref_en(input logic [3:0] m, input int i);
        int f;
        if (m == 4'b0001) return 1'b1;
        if (!m[3]) begin
            case (m[2:1])
                2'b01:   return ra[i] ^ m[0];
                2'b10:   return rb[i] ^ m[0];
                2'b11:   return rc[i] ^ m[0];
                default: return 1'b0;
            endcase
        end
        f = (6 + i) % 64;
        return crf[4*f + (3 - int'(m[2:1]))] ^ m[0];
    endfunction

    function automatic logic [63:0] ref_mask(input logic [3:0] m, input int n);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = ref_en(m, i);
        return r;
    endfunction

    // Start a sequence, scramble mode/vl after the start edge, optionally
    // pulse start again at sample restart_k, and gather the element stream.
    task automatic run_seq(input logic [3:0] m, input logic [6:0] v, input int restart_k,
                           output logic [63:0] ens, output int nval, output int done_at,
                           output bit seq_ok, output bit ill);
        @(negedge clk);
        mode = m; vl = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0; mode = ~m; vl = 7'd2;
        ens = '0; nval = 0; done_at = -1; seq_ok = 1; ill = 0;
        for (int k = 1; k <= int'(v) + 3; k++) begin
            if (k > 1) @(negedge clk);
            if (elem_valid) begin
                if (elem_idx != 6'(nval) || k != nval + 2) seq_ok = 0;
                ens[elem_idx] = elem_en;
                nval++;
            end
            if (seq_done && done_at < 0) begin
                done_at = k;
                ill = illegal_op;
            end
            if (k == restart_k) begin start = 1'b1; mode = 4'b0011; vl = 7'd3; end
            else start = 1'b0;
        end
        start = 1'b0;
    endtask

    task automatic check_run(input logic [3:0] m, input logic [6:0] v, input string req);
        logic [63:0] ens, exp;
        int nval, done_at, n;
        bit ok, ill;
        n = (v > 7'd64) ? 64 : int'(v);
        run_seq(m, v, -1, ens, nval, done_at, ok, ill);
        exp = ref_mask(m, n);
        check(ens == exp, req, ens, exp);
        check(nval == n, "R8 count", 64'(nval), 64'(n));
        check(ok, "R8 order", 64'(ok), 64'd1);
        check(done_at == ((n == 0) ? 1 : n + 2), "R9 done", 64'(done_at), 64'((n == 0) ? 1 : n + 2));
        check(!ill, "R2 no illegal", 64'(ill), 64'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; mode = '0; vl = '0;
        repeat (3) @(negedge clk);
        check({elem_valid, seq_done, illegal_op} == 3'b000, "R1 reset",
              64'({elem_valid, seq_done, illegal_op}), 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_reserved();
        logic [63:0] ens; int nval, done_at; bit ok, ill;
        run_seq(4'b0000, 7'd5, -1, ens, nval, done_at, ok, ill);
        check(ill, "R2 illegal", 64'(ill), 64'd1);
        check(done_at == 1, "R2 done timing", 64'(done_at), 64'd1);
        check(nval == 0, "R2 no strobes", 64'(nval), 64'd0);
    endtask

    task automatic t_unmasked();
        check_run(4'b0001, 7'd64, "R3 all");
        check_run(4'b0001, 7'd100, "R9 clamp");
    endtask

    task automatic t_int();
        ra = 64'hF0F0_1234_8000_0001; rb = 64'h0123_4567_89AB_CDEF; rc = 64'hDEAD_BEEF_5555_AAAA;
        check_run(4'b0010, 7'd64, "R4 set");
        check_run(4'b0011, 7'd40, "R4 clear");
        check_run(4'b0100, 7'd64, "R5 b set");
        check_run(4'b0101, 7'd17, "R5 b clear");
        check_run(4'b0110, 7'd64, "R5 c set");
        check_run(4'b0111, 7'd33, "R5 c clear");
    endtask

    task automatic t_cond();
        for (int i = 0; i < 256; i++) crf[i] = ((i * 37 + (i >> 3)) % 5) < 2;
        for (int m = 8; m < 16; m++) check_run(4'(m), 7'd64, "R7 flag");
        crf = '0; crf[3] = 1'b1;               // only field 0 less-than set
        check_run(4'b1000, 7'd64, "R6 wrap");
        crf = '0; crf[4*5 + 0] = 1'b1;         // field 5 summary-overflow
        check_run(4'b1110, 7'd64, "R6 last field");
    endtask

    task automatic t_short();
        check_run(4'b0001, 7'd0, "R9 vl0");
        check_run(4'b0010, 7'd1, "R8 vl1");
    endtask

    task automatic t_restart();
        logic [63:0] ens, exp; int nval, done_at; bit ok, ill;
        ra = 64'h0000_0000_0000_0155;
        run_seq(4'b0010, 7'd10, 4, ens, nval, done_at, ok, ill);
        exp = ref_mask(4'b0010, 10);
        check(ens == exp, "R10 mode held", ens, exp);
        check(nval == 10, "R10 length held", 64'(nval), 64'd10);
        check(done_at == 12, "R10 done", 64'(done_at), 64'd12);
    endtask

    task automatic t_mid_reset();
        @(negedge clk); mode = 4'b0001; vl = 7'd30; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check({elem_valid, seq_done, illegal_op} == 3'b000, "R1 mid reset",
              64'({elem_valid, seq_done, illegal_op}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!elem_valid, "R1 stays idle", 64'(elem_valid), 64'd0);
        check_run(4'b0001, 7'd0, "R1 idle after reset");
    endtask

    initial begin
        ra = '0; rb = '0; rc = '0; crf = '0;
        t_reset();
        t_reserved();
        t_unmasked();
        t_int();
        t_cond();
        t_short();
        t_restart();
        t_mid_reset();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule